// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block lets a processor run an 8-bit successive-approximation conversion through a small register port. It sits on a Wishbone-style port with cycle, strobe, write-enable and acknowledge lines, an 8-bit data bus and a single address bit. One control register chooses which of four reference voltages feeds the converter and carries a hold/start flag. Setting that flag freezes the analog input and launches a conversion.

The block has its own bit sequencer. It presents a trial code to an external DAC and comparator and reads back the comparator's one-bit verdict. The most significant bit is resolved first, and each later bit is resolved in turn down to bit 0. When the last bit is known, the block latches the result and raises a done flag. The processor can poll that flag on one address and read the result on the other.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After synchronous reset, the reference enable is 0001, hold is low, the trial code is 0x00, a status read returns 0x00 and a data read returns 0x00.
- R2: Acknowledge is high in exactly the cycles where both cycle and strobe are high, for reads and for writes. It is never delayed.
- R3: The control register is loaded from data bits [2:0] only when cycle, strobe and write-enable are all high. A transfer that lacks any one of these leaves reference enable, hold, trial code and done unchanged.
- R4: The reference-select field in data bits [1:0] is decoded one-hot: field value n drives reference-enable bit n alone.
- R5: The hold output equals control bit 2. Every accepted write with bit 2 set starts a conversion and clears done. A write with bit 2 clear lowers hold and does not start a conversion.
- R6: In the cycle after a starting write, the trial code is 0x7F.
- R7: Each bit takes two clocks: one clock for the comparator to settle and one to sample it. Each new trial code keeps the bits already decided, sets the bit under test to 0 and sets every lower bit to 1. A decided bit is 1 when the comparator reports that the input is above the trial code.
- R8: Done stays 0 for 16 cycles after a starting write and reads 1 from the 17th cycle. A read with address 0 then returns the converted byte. A read with address 1 returns done in bit 0 and zeros in bits 7:1. Reads do not disturb a conversion in progress.
- R9: A starting write during a conversion abandons that conversion and restarts from trial 0x7F. The restarted conversion takes the full 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busCyc | input | 1 | Bus cycle qualifier |
| busStb | input | 1 | Bus strobe |
| busWe | input | 1 | Write enable |
| busAddr | input | 1 | Register select: 0 data, 1 status |
| busDatIn | input | 8 | Write data |
| busDatOut | output | 8 | Read data |
| busAck | output | 1 | Transfer acknowledge |
| refEn | output | 4 | One-hot reference-voltage enable |
| holdOut | output | 1 | Sample/hold command to the analog front end |
| trialCode | output | 8 | Trial code to the DAC |
| cmpIn | input | 1 | Comparator result, 1 when the input is above the trial code |

## Verification
The bench runs conversions at the two rails, on either side of mid-scale and at patterned values, and checks every trial code against the sequence derived from R7. A sequencer that filled the lower bits with 0 instead of 1, or that sampled one clock early, would show a wrong trial or a wrong final byte. The bench polls status in every cycle of a conversion, so a done flag that rises early or late, or a read that upsets the sequencer, is caught. It also restarts a conversion halfway through, which exposes any stale bit index or stale decided bits. Finally it issues writes with cycle, strobe or write-enable missing, which would catch a decoder that ignores any one of them.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // Strobes passed from the sequencer control to the datapath.
  typedef struct packed {
    logic wrCtrl;     // accepted write to the control register
    logic startConv;  // accepted write with the hold/start bit set
    logic sampleBit;  // comparator is settled: decide the current bit
    logic lastBit;    // the bit being decided is bit 0
  } sarStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_SAMPLE = 2'd2
  } sarPhase_t;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_adc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busCyc,
  input  logic             busStb,
  input  logic             busWe,
  input  logic             startBit,
  output sarStrobe_t       strobe,
  output logic [IDX_W-1:0] bitIdx
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  sarPhase_t phase;
  logic      wrCtrl;
  logic      startConv;
  logic      sampleBit;

  assign wrCtrl    = busCyc & busStb & busWe;
  assign startConv = wrCtrl & startBit;
  assign sampleBit = (phase == PH_SAMPLE) & ~startConv;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      bitIdx <= '0;
    end else if (startConv) begin
      phase  <= PH_SETTLE;
      bitIdx <= TOP_IDX;
    end else begin
      case (phase)
        PH_SETTLE: phase <= PH_SAMPLE;
        PH_SAMPLE: begin
          if (bitIdx == '0) begin
            phase <= PH_IDLE;
          end else begin
            phase  <= PH_SETTLE;
            bitIdx <= bitIdx - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.wrCtrl    = wrCtrl;
    strobe.startConv = startConv;
    strobe.sampleBit = sampleBit;
    strobe.lastBit   = sampleBit & (bitIdx == '0);
  end

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_adc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REFS = 4,
  localparam int IDX_W   = $clog2(DATA_W),
  localparam int SEL_W   = $clog2(NUM_REFS)
) (
  input  logic              clk,
  input  logic              rst,
  input  sarStrobe_t        strobe,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [SEL_W:0]    ctrlIn,
  input  logic              busAddr,
  input  logic              cmpIn,
  output logic [NUM_REFS-1:0] refEn,
  output logic              holdOut,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] busDatOut,
  output logic              doneFlag,
  output logic [DATA_W-1:0] resultData
);

  localparam logic [DATA_W-1:0] FIRST_TRIAL = {1'b0, {(DATA_W-1){1'b1}}};

  logic [SEL_W:0]      ctrlReg;
  logic [SEL_W-1:0]    selField;
  logic [DATA_W-1:0]   nextTrial;
  logic [IDX_W-1:0]    lowerIdx;

  assign selField = ctrlReg[SEL_W-1:0];
  assign holdOut  = ctrlReg[SEL_W];

  // Control register
  always_ff @(posedge clk) begin
    if (rst)                ctrlReg <= '0;
    else if (strobe.wrCtrl) ctrlReg <= ctrlIn;
  end

  // One-hot reference decode
  for (genvar i = 0; i < NUM_REFS; i++) begin : g_refDec
    assign refEn[i] = (selField == SEL_W'(i));
  end

  // Next trial: decide current bit, open the next one at 0
  assign lowerIdx = bitIdx - 1'b1;

  always_comb begin
    nextTrial         = trialCode;
    nextTrial[bitIdx] = cmpIn;
    if (bitIdx != '0) nextTrial[lowerIdx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                   trialCode <= '0;
    else if (strobe.startConv) trialCode <= FIRST_TRIAL;
    else if (strobe.sampleBit) trialCode <= nextTrial;
  end

  always_ff @(posedge clk) begin
    if (rst)                 resultData <= '0;
    else if (strobe.lastBit) resultData <= nextTrial;
  end

  always_ff @(posedge clk) begin
    if (rst)                   doneFlag <= 1'b0;
    else if (strobe.startConv) doneFlag <= 1'b0;
    else if (strobe.lastBit)   doneFlag <= 1'b1;
  end

  // Read-back mux
  always_comb begin
    busDatOut = '0;
    if (busAddr) busDatOut[0] = doneFlag;
    else         busDatOut    = resultData;
  end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REFS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busCyc,
  input  logic                busStb,
  input  logic                busWe,
  input  logic                busAddr,
  input  logic [DATA_W-1:0]   busDatIn,
  output logic [DATA_W-1:0]   busDatOut,
  output logic                busAck,
  output logic [NUM_REFS-1:0] refEn,
  output logic                holdOut,
  output logic [DATA_W-1:0]   trialCode,
  input  logic                cmpIn
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int SEL_W = $clog2(NUM_REFS);

  sarStrobe_t        strobe;
  logic [IDX_W-1:0]  bitIdx;
  logic              doneFlag;
  logic [DATA_W-1:0] resultData;

  assign busAck = busCyc & busStb;

  sar_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busCyc   (busCyc),
    .busStb   (busStb),
    .busWe    (busWe),
    .startBit (busDatIn[SEL_W]),
    .strobe   (strobe),
    .bitIdx   (bitIdx)
  );

  sar_datapath #(.DATA_W(DATA_W), .NUM_REFS(NUM_REFS)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .bitIdx     (bitIdx),
    .ctrlIn     (busDatIn[SEL_W:0]),
    .busAddr    (busAddr),
    .cmpIn      (cmpIn),
    .refEn      (refEn),
    .holdOut    (holdOut),
    .trialCode  (trialCode),
    .busDatOut  (busDatOut),
    .doneFlag   (doneFlag),
    .resultData (resultData)
  );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REFS = 4,
  localparam int SEL_W   = $clog2(NUM_REFS)
) (
  input logic                clk,
  input logic                rst,
  input logic                busCyc,
  input logic                busStb,
  input logic                busWe,
  input logic [DATA_W-1:0]   busDatIn,
  input logic [NUM_REFS-1:0] refEn,
  input logic                holdOut,
  input logic [DATA_W-1:0]   trialCode,
  input logic                doneFlag,
  input logic [DATA_W-1:0]   resultData
);

  logic wrAcc;
  logic startWr;
  assign wrAcc   = busCyc & busStb & busWe;
  assign startWr = wrAcc & busDatIn[SEL_W];

  a_r4_onehot_ref: assert property (@(posedge clk) disable iff (rst)
    $countones(refEn) == 1);

  a_r3_ctrl_capture: assert property (@(posedge clk) disable iff (rst)
    wrAcc |=> holdOut == $past(busDatIn[SEL_W]));

  a_r3_ctrl_keep: assert property (@(posedge clk) disable iff (rst)
    !wrAcc |=> $stable(holdOut) && $stable(refEn));

  a_r6_first_trial: assert property (@(posedge clk) disable iff (rst)
    startWr |=> trialCode == {1'b0, {(DATA_W-1){1'b1}}});

  a_r5_done_cleared: assert property (@(posedge clk) disable iff (rst)
    startWr |=> !doneFlag);

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (doneFlag && !startWr) |=> doneFlag && $stable(resultData));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DATA_W(DATA_W), .NUM_REFS(NUM_REFS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busCyc     (busCyc),
  .busStb     (busStb),
  .busWe      (busWe),
  .busDatIn   (busDatIn),
  .refEn      (refEn),
  .holdOut    (holdOut),
  .trialCode  (trialCode),
  .doneFlag   (doneFlag),
  .resultData (resultData)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       busCyc, busStb, busWe, busAddr;
  logic [7:0] busDatIn, busDatOut;
  logic       busAck;
  logic [3:0] refEn;
  logic       holdOut;
  logic [7:0] trialCode;
  logic       cmpIn;

  int vin = 0;
  int checks = 0;
  int fails = 0;
  int cycleCount = 0;
  int startCyc = -1000;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  // Comparator model: 1 when the input is above the trial code
  assign cmpIn = (vin > int'(trialCode));

  sar_adc_ctrl u_dut (
    .clk(clk), .rst(rst), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busAddr(busAddr), .busDatIn(busDatIn), .busDatOut(busDatOut),
    .busAck(busAck), .refEn(refEn), .holdOut(holdOut),
    .trialCode(trialCode), .cmpIn(cmpIn)
  );

  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Monitor: pops expected trial codes on each settle cycle
  always @(negedge clk) begin
    int k;
    k = cycleCount - startCyc;
    if (k >= 0 && k <= 14 && (k % 2) == 0) begin
      if (expQ.size() == 0) begin
        check("R7 missing expected trial", 1, 0);
      end else if (k == 0) begin
        check("R6 first trial", int'(trialCode), int'(expQ.pop_front()));
      end else begin
        check("R7 trial sequence", int'(trialCode), int'(expQ.pop_front()));
      end
    end
  end

  // Driver helpers
  task automatic doWrite(logic [7:0] d, bit c = 1, bit s = 1, bit w = 1);
    @(negedge clk);
    busCyc = c; busStb = s; busWe = w; busAddr = 1'b0; busDatIn = d;
    #2;
    check("R2 ack on write", int'(busAck), int'(c & s));
    @(posedge clk);
    #1;
    if (c && s && w && d[2]) startCyc = cycleCount;
    busCyc = 0; busStb = 0; busWe = 0;
  endtask

  task automatic doRead(logic a, output logic [7:0] val);
    @(negedge clk);
    busCyc = 1; busStb = 1; busWe = 0; busAddr = a;
    #2;
    check("R2 ack on read", int'(busAck), 1);
    val = busDatOut;
    @(posedge clk);
    #1;
    busCyc = 0; busStb = 0;
  endtask

  function automatic int pushTrials(int v);
    int decided;
    decided = 0;
    for (int k = 7; k >= 0; k--) begin
      int t;
      t = decided | ((1 << k) - 1);
      expQ.push_back(t[7:0]);
      if (v > t) decided = decided | (1 << k);
    end
    return decided;
  endfunction

  task automatic convertTest(int v, logic [1:0] sel);
    logic [7:0] rd;
    int expRes;
    vin = v;
    expQ.delete();
    expRes = pushTrials(v);
    doWrite({5'b0, 1'b1, sel});
    check("R5 hold raised", int'(holdOut), 1);
    check("R4 one-hot ref", int'(refEn), 1 << sel);
    for (int i = 0; i < 16; i++) begin
      doRead(1'b1, rd);
      check("R8 done low while converting", int'(rd), 0);
    end
    doRead(1'b1, rd);
    check("R8 done after 16 cycles", int'(rd), 1);
    doRead(1'b0, rd);
    check("R8 result", int'(rd), expRes);
    check("R8 result equals input", int'(rd), v);
  endtask

  initial begin
    #(8 * 200000);
    check("watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] savedTrial;
    rst = 1; busCyc = 0; busStb = 0; busWe = 0; busAddr = 0; busDatIn = 0;
    repeat (4) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    @(negedge clk);
    check("R1 refEn", int'(refEn), 1);
    check("R1 hold", int'(holdOut), 0);
    check("R1 trial", int'(trialCode), 0);
    doRead(1'b1, rd); check("R1 status", int'(rd), 0);
    doRead(1'b0, rd); check("R1 data", int'(rd), 0);

    // R4 decode of every select value, no start
    for (int s = 0; s < 4; s++) begin
      doWrite(8'(s));
      check("R4 one-hot ref", int'(refEn), 1 << s);
      check("R5 hold stays low", int'(holdOut), 0);
    end
    check("R5 no start without bit 2", int'(trialCode), 0);

    // R7/R8 conversions over several input patterns
    convertTest(0, 2'd0);
    convertTest(255, 2'd1);
    convertTest(128, 2'd2);
    convertTest(127, 2'd3);
    convertTest(8'hA5, 2'd1);
    convertTest(8'h3C, 2'd2);

    // R9 restart mid-conversion
    vin = 8'h11;
    expQ.delete();
    void'(pushTrials(8'h11));
    doWrite(8'h04);
    for (int i = 0; i < 5; i++) doRead(1'b1, rd);
    vin = 8'hC3;
    expQ.delete();
    void'(pushTrials(8'hC3));
    doWrite(8'h07);
    check("R9 restart trial", int'(trialCode), 8'h7F);
    for (int i = 0; i < 16; i++) begin
      doRead(1'b1, rd);
      check("R9 done low after restart", int'(rd), 0);
    end
    doRead(1'b1, rd); check("R9 done after full restart", int'(rd), 1);
    doRead(1'b0, rd); check("R9 restarted result", int'(rd), 8'hC3);

    // R3 incomplete transfers are ignored
    savedTrial = trialCode;
    doWrite(8'h00, 0, 1, 1);
    doWrite(8'h00, 1, 0, 1);
    doWrite(8'h00, 1, 1, 0);
    check("R3 refEn kept", int'(refEn), 4'b1000);
    check("R3 hold kept", int'(holdOut), 1);
    check("R3 trial kept", int'(trialCode), int'(savedTrial));
    doRead(1'b1, rd); check("R3 done kept", int'(rd), 1);

    // R5 lowering hold does not start a conversion
    doWrite(8'h02);
    check("R5 hold lowered", int'(holdOut), 0);
    check("R4 ref after clear", int'(refEn), 4'b0100);
    check("R5 trial unchanged", int'(trialCode), int'(savedTrial));
    doRead(1'b1, rd); check("R5 done kept", int'(rd), 1);
    doRead(1'b0, rd); check("R5 data kept", int'(rd), 8'hC3);

    // R2 no ack without strobe
    @(negedge clk);
    busCyc = 1; busStb = 0; busWe = 0;
    #2 check("R2 no ack without strobe", int'(busAck), 0);
    busCyc = 0;
    repeat (2) @(posedge clk);
    check("R7 queue drained", expQ.size(), 0);

    summary();
    $finish;
  end

endmodule